// File: doc/BRIEF.md
# Two-Context Shared-Core Issue Arbiter

This block sits in front of one execution core that two hardware thread contexts share. Each context keeps its own program counter. Each context also presents a request-valid line and a stall line. In every cycle the arbiter picks at most one context whose instruction address goes into the core. The pick is registered and presented as a one-hot grant, a thread number and the program counter being issued.

A context may issue in a cycle only when its valid line is high and its stall line is low. When both contexts can issue, they take strictly alternate cycles. When only one can issue, it receives every cycle. The core sits idle only when neither context can issue. A granted context's program counter steps by 4. A per-context redirect loads a new target in place of the stepped value.

Top module: `dual_ctx_issue_arb`

## Requirements
- R1: During reset, and at the first clock after it, the grant is 2'b00, the thread number is 0 and the issued PC is 0. Context PCs reset to RESET_PCS (context 0 in the low PC_W bits). The first cycle in which both contexts can issue goes to context 0.
- R2: While both contexts can issue on consecutive cycles, the grant alternates between 2'b01 (context 0) and 2'b10 (context 1) on every cycle.
- R3: When exactly one context can issue, because the other is stalled, that context is granted on every such cycle.
- R4: When no context can issue, the grant is 2'b00 and the thread number and issued PC keep their previous values.
- R5: When both contexts can issue after one or more cycles in which they could not, the grant goes to the context that did not receive the most recent grant.
- R6: Inputs sampled at a clock edge decide the grant shown after that same edge. The grant has at most one bit set, with bit i meaning context i. The thread number and the issued PC belong to the granted context.
- R7: A granted context without a redirect issues its current PC, and its PC then becomes that value plus 4.
- R8: A redirect on a context replaces its PC with the target. If that context is granted in the same cycle, it issues the target and its PC becomes the target plus 4.
- R9: A context whose valid line is low is never granted, even when it is not stalled.
- R10: A context that is neither granted nor redirected keeps its PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-context request valid, bit i for context i |
| stall | input | 2 | Per-context stall, bit i for context i |
| redir_valid | input | 2 | Per-context redirect strobe |
| redir_pc | input | 2*PC_W | Redirect targets, context 0 in the low PC_W bits |
| grant | output | 2 | Registered one-hot grant |
| grant_tid | output | 1 | Registered number of the granted context |
| grant_pc | output | PC_W | Registered PC issued to the core |

## Verification
The assertions expect every input to be at a known level at each clock edge. They ignore a redirect target whose strobe is low. Stall and valid may change in any cycle, with no ordering between them. The stimulus changes inputs only on the falling clock edge. It drives every line, targets included, to a defined value in each vector, and it steps through run, single-stall, double-stall, invalid and redirect patterns in turn.

// File: rtl/mtia_pkg.sv
package mtia_pkg;
  localparam int unsigned NCTX = 2;
  typedef logic [NCTX-1:0] ctx_vec_t;
endpackage

// File: rtl/mtia_pick.sv
module mtia_pick
  import mtia_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ctx_vec_t elig,
  output ctx_vec_t sel_d,
  output ctx_vec_t grant_q
);
  logic last_q;

  always_comb begin
    unique case (elig)
      2'b11:   sel_d = last_q ? 2'b01 : 2'b10;
      2'b01:   sel_d = 2'b01;
      2'b10:   sel_d = 2'b10;
      default: sel_d = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= 1'b1;
    end else begin
      grant_q <= sel_d;
      if (|sel_d) last_q <= sel_d[1];
    end
  end

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b11 && grant_q != 2'b00) |=> (grant_q == ~$past(grant_q))); // R2
  AST_SOLE_CTX0: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b01) |=> (grant_q == 2'b01)); // R3
  AST_SOLE_CTX1: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b10) |=> (grant_q == 2'b10)); // R3
  AST_IDLE_CORE: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b00) |=> (grant_q == 2'b00)); // R4
endmodule

// File: rtl/mtia_ctx_pc.sv
module mtia_ctx_pc #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned STEP     = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            redir_vld,
  input  logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] eff_pc,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  assign eff_pc = redir_vld ? redir_pc : pc_q;

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= RESET_PC;
    else if (sel) pc_q <= eff_pc + STEP_V;
    else          pc_q <= eff_pc;
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (sel && !redir_vld) |=> (pc_q == $past(pc_q) + STEP_V)); // R7
  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (sel && redir_vld) |=> (pc_q == $past(redir_pc) + STEP_V)); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sel && !redir_vld) |=> $stable(pc_q)); // R10
endmodule

// File: rtl/mtia_issue_reg.sv
module mtia_issue_reg
  import mtia_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctx_vec_t             sel_d,
  input  logic [NCTX*PC_W-1:0] eff_pcs,
  output logic                 tid_q,
  output logic [PC_W-1:0]      pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tid_q <= 1'b0;
      pc_q  <= '0;
    end else if (sel_d[1]) begin
      tid_q <= 1'b1;
      pc_q  <= eff_pcs[PC_W +: PC_W];
    end else if (sel_d[0]) begin
      tid_q <= 1'b0;
      pc_q  <= eff_pcs[0 +: PC_W];
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel_d == 2'b00) |=> ($stable(tid_q) && $stable(pc_q))); // R4
endmodule

// File: rtl/dual_ctx_issue_arb.sv
module dual_ctx_issue_arb
  import mtia_pkg::*;
#(
  parameter int unsigned PC_W = 32,
  parameter int unsigned STEP = 4,
  parameter logic [NCTX*PC_W-1:0] RESET_PCS = {32'h0000_2000, 32'h0000_1000}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCTX-1:0]      req_valid,
  input  logic [NCTX-1:0]      stall,
  input  logic [NCTX-1:0]      redir_valid,
  input  logic [NCTX*PC_W-1:0] redir_pc,
  output logic [NCTX-1:0]      grant,
  output logic                 grant_tid,
  output logic [PC_W-1:0]      grant_pc
);
  ctx_vec_t             elig;
  ctx_vec_t             sel_d;
  logic [NCTX*PC_W-1:0] eff_pcs;
  logic [NCTX*PC_W-1:0] ctx_pcs;

  assign elig = req_valid & ~stall;

  mtia_pick u_pick (
    .clk     (clk),
    .rst     (rst),
    .elig    (elig),
    .sel_d   (sel_d),
    .grant_q (grant)
  );

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    mtia_ctx_pc #(
      .PC_W     (PC_W),
      .STEP     (STEP),
      .RESET_PC (RESET_PCS[i*PC_W +: PC_W])
    ) u_ctx (
      .clk       (clk),
      .rst       (rst),
      .sel       (sel_d[i]),
      .redir_vld (redir_valid[i]),
      .redir_pc  (redir_pc[i*PC_W +: PC_W]),
      .eff_pc    (eff_pcs[i*PC_W +: PC_W]),
      .pc_q      (ctx_pcs[i*PC_W +: PC_W])
    );

    AST_NO_INVALID_GRANT: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> $past(req_valid[i] && !stall[i])); // R9
  end

  mtia_issue_reg #(.PC_W(PC_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .sel_d   (sel_d),
    .eff_pcs (eff_pcs),
    .tid_q   (grant_tid),
    .pc_q    (grant_pc)
  );

  AST_TID_MATCH: assert property (@(posedge clk) disable iff (rst)
    (grant != 2'b00) |-> (grant_tid == grant[1])); // R6

  logic unused_pcs;
  assign unused_pcs = ^ctx_pcs;
endmodule

// File: tb/dual_ctx_issue_arb_tb.sv
module dual_ctx_issue_arb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_valid = '0, stall = '0, redir_valid = '0;
  logic [63:0] redir_pc = '0;
  logic [1:0]  grant;
  logic        grant_tid;
  logic [31:0] grant_pc;

  always #5 clk = ~clk;

  dual_ctx_issue_arb u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .stall(stall),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .grant(grant), .grant_tid(grant_tid), .grant_pc(grant_pc)
  );

  typedef struct {
    logic [1:0]  g;
    logic        t;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int nchk = 0, nfail = 0;

  logic        m_last = 1'b1;
  logic [31:0] m_pc0 = 32'h0000_1000, m_pc1 = 32'h0000_2000;
  logic        m_tid = 1'b0;
  logic [31:0] m_gpc = 32'h0;
  logic        m_first = 1'b1, m_gap = 1'b0;

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      nchk++;
      if (grant !== mon_e.g || grant_tid !== mon_e.t || grant_pc !== mon_e.pc) begin
        nfail++;
        $display("FAIL %s: got grant=%b tid=%0d pc=%h, expected grant=%b tid=%0d pc=%h",
                 mon_e.tag, grant, grant_tid, grant_pc, mon_e.g, mon_e.t, mon_e.pc);
      end
    end
  end

  task automatic step(input logic [1:0] rv, input logic [1:0] st,
                      input logic [1:0] rdv, input logic [31:0] a0, input logic [31:0] a1);
    logic [1:0]  el, sel;
    logic [31:0] e0, e1;
    exp_t        x;
    @(negedge clk);
    req_valid = rv; stall = st; redir_valid = rdv; redir_pc = {a1, a0};
    el = rv & ~st;
    case (el)
      2'b11:   sel = m_last ? 2'b01 : 2'b10;
      2'b01:   sel = 2'b01;
      2'b10:   sel = 2'b10;
      default: sel = 2'b00;
    endcase
    e0 = rdv[0] ? a0 : m_pc0;
    e1 = rdv[1] ? a1 : m_pc1;
    if (sel != 2'b00) begin
      m_tid  = sel[1];
      m_gpc  = sel[1] ? e1 : e0;
      m_last = sel[1];
    end
    m_pc0 = sel[0] ? e0 + 32'd4 : e0;
    m_pc1 = sel[1] ? e1 + 32'd4 : e1;
    if (m_first && el == 2'b11)            x.tag = "R1 R7";
    else if (|(rdv & sel))                  x.tag = "R8";
    else if (rdv != 2'b00)                  x.tag = "R8 R10";
    else if (el == 2'b11 && m_gap)          x.tag = "R5 R7";
    else if (el == 2'b11)                   x.tag = "R2 R6 R7";
    else if (el == 2'b00)                   x.tag = "R4";
    else if ((rv & ~st) != ~st)             x.tag = "R9 R3";
    else                                    x.tag = "R3 R10";
    m_first = 1'b0;
    m_gap   = (el != 2'b11);
    x.g = sel; x.t = m_tid; x.pc = m_gpc;
    exp_q.push_back(x);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    nchk++;
    if (grant !== 2'b00 || grant_tid !== 1'b0 || grant_pc !== 32'h0) begin
      nfail++;
      $display("FAIL R1 reset: got grant=%b tid=%0d pc=%h, expected grant=00 tid=0 pc=0",
               grant, grant_tid, grant_pc);
    end
    @(negedge clk); rst = 1'b0;
    repeat (5) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    repeat (3) step(2'b11, 2'b10, 2'b00, 32'h0, 32'h0);
    repeat (3) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    repeat (3) step(2'b11, 2'b01, 2'b00, 32'h0, 32'h0);
    repeat (2) step(2'b11, 2'b11, 2'b00, 32'h0, 32'h0);
    repeat (2) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    repeat (3) step(2'b10, 2'b00, 2'b00, 32'h0, 32'h0);
    step(2'b00, 2'b00, 2'b00, 32'h0, 32'h0);
    step(2'b11, 2'b00, 2'b11, 32'h0000_4000, 32'h0000_8000);
    repeat (4) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    step(2'b01, 2'b10, 2'b10, 32'h0, 32'h0000_C000);
    repeat (3) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    step(2'b11, 2'b00, 2'b01, 32'h0000_0100, 32'h0);
    repeat (2) step(2'b11, 2'b00, 2'b00, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule